// File: doc/BRIEF.md
# Clock-Calendar Time Counter

This block keeps the time of day and the calendar date. A 32.768 kHz timebase arrives on `osc_in` as a slow square wave. It is synchronised into the system clock domain, and its rising edges are counted down to one tick per second. Each tick advances a chain of packed-BCD fields in one system clock cycle: seconds, minutes, hours, day of week, date, month and a two-digit year. Month lengths, leap years and the 12-hour or 24-hour hour format are all handled inside the chain.

A host loads any field through a one-cycle write strobe with a field select. All fields sit in registers and drive the read outputs directly. The hour field has a mode bit that selects 12-hour display with an AM/PM bit. A sticky flag reports that the timebase was not running. It is set at reset and whenever the timebase goes quiet for longer than a timeout window, and it is cleared only by the host.

Top module: `tod_calendar`

## Requirements
- R1: Seconds advance by exactly one after every `PRESCALE` rising edges of `osc_in`. A host write to the seconds field restarts that edge count from zero.
- R2: Seconds and minutes count BCD 00 to 59. Each wraps to 00 and carries into the next field. In 24-hour mode (hour bit 6 = 0, bits 5:0 BCD 00–23) the hour wraps from 23 to 00 and advances the day.
- R3: In 12-hour mode (hour bit 6 = 1, bit 5 = PM, bits 4:0 BCD 01–12) the hour runs 12, 01, 02 … 11. The PM bit flips on the step from 11 to 12. The day advances on the step from 11 PM to 12 AM.
- R4: Day of week counts 1 to 7 and wraps from 7 to 1 when the day advances. It does not depend on the date.
- R5: The date (BCD) returns to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R6: February has a 29th day when the BCD year, read as a number, is divisible by 4 (year 00 included). Otherwise the date goes from February 28 to March 01.
- R7: The month (BCD 01–12) wraps from 12 to 01 and advances the year. The year (BCD) wraps from 99 to 00.
- R8: The timebase-stop flag reads 1 after reset. It sets when no rising edge of `osc_in` arrives for `STOP_TIMEOUT` clock cycles. Writing the status field with bit 0 = 0 clears it. Writing bit 0 = 1 leaves it unchanged.
- R9: When a host write and a tick update hit the same field in the same cycle, the field takes the written value. Fields that are not written still advance.
- R10: Field select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 status. After reset the fields read 00, 00, 00 (24-hour mode), 1, 01, 01, 00, and a written field reads back its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | 32.768 kHz timebase, asynchronous to clk |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value, packed BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode bit 6 and PM bit 5 |
| dow_o | output | 8 | Day of week 1–7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00–99, BCD |
| osc_stop_o | output | 1 | Sticky timebase-stop flag |

## Verification
Each field is a register wired straight to an output, so a wrong state in the chain shows at the ports one clock after the tick that caused it. A miscounted prescaler shows only as a second arriving one timebase edge early or late, so the bench counts edges exactly after restarting the prescaler. Wrong carry logic hides until a boundary is crossed. For that reason every wrap (minute, midnight in both hour modes, each month length, leap and non-leap February, year end) is loaded by a write and then crossed with a single second.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [2:0] FLD_SEC   = 3'd0;
  localparam logic [2:0] FLD_MIN   = 3'd1;
  localparam logic [2:0] FLD_HOUR  = 3'd2;
  localparam logic [2:0] FLD_DOW   = 3'd3;
  localparam logic [2:0] FLD_DATE  = 3'd4;
  localparam logic [2:0] FLD_MONTH = 3'd5;
  localparam logic [2:0] FLD_YEAR  = 3'd6;
  localparam logic [2:0] FLD_STAT  = 3'd7;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit year is a leap year when its numeric value is a multiple of four.
  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] t;
    logic [7:0] val;
    t   = {4'd0, y[7:4]};
    val = (t << 3) + (t << 1) + {4'd0, y[3:0]};
    return (val % 8'd4) == 8'd0;
  endfunction

  // Last date of the month, in BCD.
  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
    if (m == 8'h02) return leap ? 8'h29 : 8'h28;
    else if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    else return 8'h31;
  endfunction
endpackage

// File: rtl/tod_timebase.sv
module tod_timebase import tod_pkg::*; #(
  parameter int PRESCALE     = 32768,
  parameter int STOP_TIMEOUT = 8192,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_in,
  input  logic presc_clr,
  output logic sec_tick,
  output logic stop_evt
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int WW = $clog2(STOP_TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PRESCALE - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(STOP_TIMEOUT - 1);
  localparam logic [WW-1:0] WD_FULL  = WW'(STOP_TIMEOUT);

  logic [SYNC_STAGES:0] sync_q;
  logic                 osc_rise;
  logic [CW-1:0]        cnt_q;
  logic [WW-1:0]        wd_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], osc_in};
  end

  assign osc_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst || presc_clr) begin
      cnt_q    <= '0;
      sec_tick <= 1'b0;
    end else if (osc_rise) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        sec_tick <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        sec_tick <= 1'b0;
      end
    end else begin
      sec_tick <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q     <= '0;
      stop_evt <= 1'b0;
    end else if (osc_rise) begin
      wd_q     <= '0;
      stop_evt <= 1'b0;
    end else if (wd_q == WD_LAST) begin
      wd_q     <= WD_FULL;
      stop_evt <= 1'b1;
    end else begin
      if (wd_q != WD_FULL) wd_q <= wd_q + 1'b1;
      stop_evt <= 1'b0;
    end
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);
  assert_stop_needs_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    osc_rise |=> !stop_evt);
endmodule

// File: rtl/tod_clock.sv
module tod_clock import tod_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [6:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_inc
);
  logic       sec_wr, min_wr, hour_wr;
  logic       min_step, hour_step, hour_last;
  logic [7:0] h12, inc12, inc24, hour_nxt;

  assign sec_wr  = wr_en && (wr_sel == FLD_SEC);
  assign min_wr  = wr_en && (wr_sel == FLD_MIN);
  assign hour_wr = wr_en && (wr_sel == FLD_HOUR);

  assign min_step  = tick && (sec_q == 8'h59);
  assign hour_step = min_step && (min_q == 8'h59);

  always_comb begin
    h12   = {3'b000, hour_q[4:0]};
    inc12 = bcd_next(h12);
    inc24 = bcd_next({2'b00, hour_q[5:0]});
    if (hour_q[6]) begin
      hour_last = (h12 == 8'h11) && hour_q[5];
      if (h12 == 8'h12) hour_nxt = {2'b01, hour_q[5], 5'h01};
      else              hour_nxt = (inc12 & 8'h1F) | {2'b01, hour_q[5] ^ (h12 == 8'h11), 5'b0};
    end else begin
      hour_last = (hour_q[5:0] == 6'h23);
      hour_nxt  = hour_last ? 8'h00 : (inc24 & 8'h3F);
    end
  end

  assign day_inc = hour_step && hour_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (sec_wr)        sec_q <= {1'b0, wr_data};
      else if (tick)     sec_q <= (sec_q == 8'h59) ? 8'h00 : bcd_next(sec_q);
      if (min_wr)        min_q <= {1'b0, wr_data};
      else if (min_step) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_next(min_q);
      if (hour_wr)        hour_q <= {1'b0, wr_data};
      else if (hour_step) hour_q <= hour_nxt;
    end
  end

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !sec_wr && sec_q == 8'h59) |=> (sec_q == 8'h00));
  assert_pm_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (hour_step && !hour_wr && hour_q[6] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));
  assert_hour_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hour_wr) |=> $stable(hour_q));
endmodule

// File: rtl/tod_date.sv
module tod_date import tod_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       day_inc,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);
  logic       dow_wr, date_wr, month_wr, year_wr;
  logic       leap, month_step, year_step;
  logic [7:0] last_day;

  assign dow_wr   = wr_en && (wr_sel == FLD_DOW);
  assign date_wr  = wr_en && (wr_sel == FLD_DATE);
  assign month_wr = wr_en && (wr_sel == FLD_MONTH);
  assign year_wr  = wr_en && (wr_sel == FLD_YEAR);

  assign leap       = is_leap(year_q);
  assign last_day   = month_last_day(month_q, leap);
  assign month_step = day_inc && (date_q == last_day);
  assign year_step  = month_step && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      dow_q   <= 8'd1;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (dow_wr)       dow_q <= {5'b0, wr_data[2:0]};
      else if (day_inc) dow_q <= (dow_q == 8'd7) ? 8'd1 : dow_q + 8'd1;
      if (date_wr)      date_q <= {2'b0, wr_data[5:0]};
      else if (day_inc) date_q <= month_step ? 8'h01 : bcd_next(date_q);
      if (month_wr)        month_q <= {3'b0, wr_data[4:0]};
      else if (month_step) month_q <= (month_q == 8'h12) ? 8'h01 : bcd_next(month_q);
      if (year_wr)        year_q <= wr_data;
      else if (year_step) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_next(year_q);
    end
  end

  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (day_inc && !dow_wr && dow_q == 8'd7) |=> (dow_q == 8'd1));
  assert_feb_leap_R6: assert property (@(posedge clk) disable iff (rst)
    (day_inc && !date_wr && month_q == 8'h02 && date_q == 8'h28 && is_leap(year_q)) |=> (date_q == 8'h29));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == FLD_DATE) |=> (date_q == {2'b0, $past(wr_data[5:0])}));
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar import tod_pkg::*; #(
  parameter int PRESCALE     = 32768,
  parameter int STOP_TIMEOUT = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_in,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       osc_stop_o
);
  logic sec_tick, stop_evt, day_inc, presc_clr, stat_wr;

  assign presc_clr = wr_en && (wr_sel == FLD_SEC);
  assign stat_wr   = wr_en && (wr_sel == FLD_STAT);

  tod_timebase #(.PRESCALE(PRESCALE), .STOP_TIMEOUT(STOP_TIMEOUT), .SYNC_STAGES(2)) u_base (
    .clk(clk), .rst(rst), .osc_in(osc_in), .presc_clr(presc_clr),
    .sec_tick(sec_tick), .stop_evt(stop_evt)
  );

  tod_clock u_clock (
    .clk(clk), .rst(rst), .tick(sec_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data[6:0]), .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .day_inc(day_inc)
  );

  tod_date u_date (
    .clk(clk), .rst(rst), .day_inc(day_inc), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dow_q(dow_o), .date_q(date_o), .month_q(month_o),
    .year_q(year_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                        osc_stop_o <= 1'b1;
    else if (stop_evt)              osc_stop_o <= 1'b1;
    else if (stat_wr && !wr_data[0]) osc_stop_o <= 1'b0;
  end

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !wr_data[0] && !stop_evt) |=> !osc_stop_o);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (osc_stop_o && !stat_wr) |=> osc_stop_o);
endmodule

// File: tb/tod_calendar_test.sv
`timescale 1ns/1ps
module tod_calendar_test;
  localparam int PS = 8;
  localparam int TO = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       osc_stop_o;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  tod_calendar #(.PRESCALE(PS), .STOP_TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .osc_in(osc_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .osc_stop_o(osc_stop_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_field(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic osc_pulse();
    @(negedge clk);
    osc_in = 1'b1;
    repeat (4) @(negedge clk);
    osc_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic one_second();
    for (int i = 0; i < PS; i++) osc_pulse();
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    write_field(3'd2, h);
    write_field(3'd1, m);
    write_field(3'd0, s);
  endtask

  task automatic set_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    write_field(3'd6, y);
    write_field(3'd5, mo);
    write_field(3'd4, d);
  endtask

  task automatic test_reset_R10();
    check("R10 reset sec", sec_o, 8'h00);
    check("R10 reset min", min_o, 8'h00);
    check("R10 reset hour", hour_o, 8'h00);
    check("R10 reset dow", dow_o, 8'd1);
    check("R10 reset date", date_o, 8'h01);
    check("R10 reset month", month_o, 8'h01);
    check("R10 reset year", year_o, 8'h00);
    check("R8 reset flag", {7'b0, osc_stop_o}, 8'd1);
    write_field(3'd6, 8'h57);
    check("R10 year readback", year_o, 8'h57);
  endtask

  task automatic test_prescale_R1();
    write_field(3'd0, 8'h10);
    for (int i = 0; i < PS - 1; i++) osc_pulse();
    check("R1 before last edge", sec_o, 8'h10);
    osc_pulse();
    check("R1 after last edge", sec_o, 8'h11);
    for (int i = 0; i < 4; i++) osc_pulse();
    write_field(3'd0, 8'h20);
    for (int i = 0; i < PS - 1; i++) osc_pulse();
    check("R1 restart held", sec_o, 8'h20);
    osc_pulse();
    check("R1 restart step", sec_o, 8'h21);
  endtask

  task automatic test_24h_R2();
    set_time(8'h12, 8'h34, 8'h59);
    one_second();
    check("R2 minute carry sec", sec_o, 8'h00);
    check("R2 minute carry min", min_o, 8'h35);
    check("R2 minute carry hour", hour_o, 8'h12);
    write_field(3'd3, 8'd3);
    set_date(8'h21, 8'h05, 8'h10);
    set_time(8'h23, 8'h59, 8'h59);
    one_second();
    check("R2 midnight hour", hour_o, 8'h00);
    check("R2 midnight min", min_o, 8'h00);
    check("R2 midnight date", date_o, 8'h11);
    check("R4 dow step", dow_o, 8'd4);
  endtask

  task automatic test_12h_R3();
    set_time(8'h51, 8'h59, 8'h59);
    one_second();
    check("R3 11AM to 12PM", hour_o, 8'h72);
    set_time(8'h72, 8'h59, 8'h59);
    one_second();
    check("R3 12PM to 1PM", hour_o, 8'h61);
    set_date(8'h21, 8'h05, 8'h05);
    set_time(8'h71, 8'h59, 8'h59);
    one_second();
    check("R3 11PM to 12AM", hour_o, 8'h52);
    check("R3 day carry", date_o, 8'h06);
  endtask

  task automatic test_dow_R4();
    write_field(3'd3, 8'd7);
    set_date(8'h21, 8'h03, 8'h15);
    set_time(8'h23, 8'h59, 8'h59);
    one_second();
    check("R4 dow wrap", dow_o, 8'd1);
    check("R4 date independent", date_o, 8'h16);
  endtask

  task automatic midnight(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    set_date(y, mo, d);
    set_time(8'h23, 8'h59, 8'h59);
    one_second();
  endtask

  task automatic test_month_R5();
    midnight(8'h21, 8'h04, 8'h30);
    check("R5 30-day date", date_o, 8'h01);
    check("R5 30-day month", month_o, 8'h05);
    midnight(8'h21, 8'h01, 8'h30);
    check("R5 31-day no wrap", date_o, 8'h31);
    one_second();
    check("R5 no step mid-day", date_o, 8'h31);
    midnight(8'h21, 8'h01, 8'h31);
    check("R5 31-day date", date_o, 8'h01);
    check("R5 31-day month", month_o, 8'h02);
    midnight(8'h21, 8'h11, 8'h30);
    check("R5 november month", month_o, 8'h12);
  endtask

  task automatic test_leap_R6();
    midnight(8'h24, 8'h02, 8'h28);
    check("R6 leap 24 feb29", date_o, 8'h29);
    check("R6 leap 24 month", month_o, 8'h02);
    midnight(8'h24, 8'h02, 8'h29);
    check("R6 leap end date", date_o, 8'h01);
    check("R6 leap end month", month_o, 8'h03);
    midnight(8'h23, 8'h02, 8'h28);
    check("R6 common year", month_o, 8'h03);
    midnight(8'h00, 8'h02, 8'h28);
    check("R6 year 00 leap", date_o, 8'h29);
    midnight(8'h10, 8'h02, 8'h28);
    check("R6 year 10 common", date_o, 8'h01);
    midnight(8'h12, 8'h02, 8'h28);
    check("R6 year 12 leap", date_o, 8'h29);
  endtask

  task automatic test_year_R7();
    midnight(8'h99, 8'h12, 8'h31);
    check("R7 century month", month_o, 8'h01);
    check("R7 century year", year_o, 8'h00);
    check("R7 century date", date_o, 8'h01);
    midnight(8'h45, 8'h12, 8'h31);
    check("R7 year step", year_o, 8'h46);
  endtask

  task automatic test_flag_R8();
    osc_pulse();
    write_field(3'd7, 8'h00);
    check("R8 flag cleared", {7'b0, osc_stop_o}, 8'd0);
    write_field(3'd7, 8'h01);
    check("R8 write one ignored", {7'b0, osc_stop_o}, 8'd0);
    repeat (TO + 40) @(negedge clk);
    check("R8 flag on timeout", {7'b0, osc_stop_o}, 8'd1);
  endtask

  task automatic test_priority_R9();
    set_time(8'h05, 8'h10, 8'h59);
    for (int i = 0; i < PS - 1; i++) osc_pulse();
    @(negedge clk);
    osc_in = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    osc_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 written min wins", min_o, 8'h33);
    check("R9 sec still wraps", sec_o, 8'h00);
    check("R9 hour untouched", hour_o, 8'h05);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset_R10();
    test_prescale_R1();
    test_24h_R2();
    test_12h_R3();
    test_dow_R4();
    test_month_R5();
    test_leap_R6();
    test_year_R7();
    test_flag_R8();
    test_priority_R9();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule